// File: doc/BRIEF.md
# Multi-Mode Low-Frequency Downlink Transmitter

This block turns one command request into the on/off gating pattern of a low-frequency reader carrier, which is how a reader talks down to a passive tag. A request carries a password, a data word, a 3-bit block address, a page bit, a 2-bit encoding select and five flags: use-password, test, reset, read and register-read. On acceptance the block builds the command bit frame in a single cycle. It then switches the carrier off for a start gap, and sends every symbol as a carrier-on interval followed by a carrier-off write gap.

All durations are counted in carrier cycles. Each carrier cycle appears as a one-clock `tick` pulse, so the block runs at any ratio between system clock and carrier. Four encodings are offered. Fixed-bit and long-reference send one bit per symbol, with long-reference adding an extended reference pulse first. Leading-zero uses a shorter 1 symbol and a leading 0 bit. Dibit mode sends two bits per symbol with four pulse lengths. The fields of the frame depend on the kind of command. A one-cycle `done` pulse marks the end of the frame, and the carrier then rests on again.

Top module: `lf_downlink_tx`

## Requirements
- R1: After reset and whenever idle, `field_on` is 1, `busy` is 0 and `done` is 0.
- R2: On the clock edge where an idle block samples `req_valid`=1, `busy` rises and `field_on` goes to 0 for a start gap of 31 ticks.
- R3: Mode encoding `dl_mode`: 0 fixed-bit, 1 long-reference, 2 leading-zero, 3 dibit. In modes 0 and 1 a 0 bit is 18 ticks of field on and a 1 bit is 50 ticks. In every mode each symbol is followed by 20 ticks of field off.
- R4: In mode 2 a 0 bit is 18 ticks on and a 1 bit is 40 ticks on. One 0 bit precedes the opcode.
- R5: In mode 3 two 0 bits precede the opcode, and bits are sent in pairs with the earlier bit as the high bit. The on-times are 18 ticks for pair 00, 34 for 01, 50 for 10 and 66 for 11.
- R6: In mode 1 a reference pulse of 154 ticks on (0-bit time plus 136) and then a 20-tick gap follow the start gap, before the first frame symbol.
- R7: The opcode is two bits. A normal command sends 1 then the page bit. When `test_mode`=1 it sends 0 then 1. When `reset_cmd`=1 it sends 0,0 and no further fields.
- R8: When `use_pwd`=1, the 32 password bits follow the opcode MSB first. In modes 2 and 3 two fixed 0 bits come before them.
- R9: The remaining fields are a 0 lock bit, then 32 data bits MSB first, then 3 address bits MSB first. `read_cmd`=1 omits the data bits. `reg_read`=1 omits the lock bit and the address bits.
- R10: `done` is high for exactly one cycle. That cycle follows the edge that ends the last write gap, and in it `field_on` is 1 and `busy` is 0.
- R11: A request made while `busy` is 1 is ignored, and the frame in progress continues unchanged.
- R12: Timing advances only on cycles where `tick` is 1. The field level changes during a frame only on edges where `tick` was sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per carrier cycle |
| req_valid | input | 1 | Command request, sampled when idle |
| pwd | input | 32 | Password word |
| data | input | 32 | Data word to write |
| addr | input | 3 | Block address |
| page | input | 1 | Page select bit |
| use_pwd | input | 1 | Include password field |
| test_mode | input | 1 | Use the test opcode |
| reset_cmd | input | 1 | Send the reset opcode only |
| read_cmd | input | 1 | Omit the data field |
| reg_read | input | 1 | Omit the lock bit and the address |
| dl_mode | input | 2 | Downlink encoding select |
| field_on | output | 1 | Carrier enable (1 = on) |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The request is sampled at a rising edge, and `field_on` falls in the cycle right after it. Every later level change falls in the cycle after the edge that counted the last tick of the current interval, and `done` appears in the cycle after the edge that ends the final gap. The bench model follows the same rule: it counts ticks at each rising edge and updates its expected `field_on`, `busy` and `done`. All three outputs are compared with the model at every falling edge, so each transition is checked in the exact cycle it is due. Sparse tick patterns are included so that a transition made one clock early or late shows up as a mismatch.

// File: rtl/lfd_pkg.sv
package lfd_pkg;

    localparam int FRAME_W = 80;
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        DL_FIXED    = 2'd0,
        DL_LONGREF  = 2'd1,
        DL_LEADZERO = 2'd2,
        DL_DIBIT    = 2'd3
    } dl_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_REF,
        ST_ON,
        ST_GAP
    } tx_state_e;

    typedef struct packed {
        logic [31:0] pwd;
        logic [31:0] data;
        logic [2:0]  addr;
        logic        page;
        logic        use_pwd;
        logic        test;
        logic        rst_cmd;
        logic        rd;
        logic        regrd;
        dl_mode_e    mode;
    } cmd_t;

    // Place the n low bits of v into frame f starting at send position pos.
    // The bit at FRAME_W-1 is the first one sent; the upper bits of v must be zero.
    function automatic logic [FRAME_W-1:0] put_bits(input logic [FRAME_W-1:0] f,
                                                    input logic [31:0] v,
                                                    input int pos,
                                                    input int n);
        logic [FRAME_W-1:0] w;
        w = '0;
        w[31:0] = v;
        return f | (w << (FRAME_W - pos - n));
    endfunction

endpackage

// File: rtl/lfd_frame_build.sv
module lfd_frame_build
    import lfd_pkg::*;
(
    input  cmd_t             cmd,
    output logic [FRAME_W-1:0] frame,
    output logic [LEN_W-1:0]   nbits
);
    always_comb begin
        logic [FRAME_W-1:0] f;
        int pos;
        logic two_zero_modes;
        f = '0;
        pos = 0;
        two_zero_modes = (cmd.mode == DL_LEADZERO) || (cmd.mode == DL_DIBIT);
        // Preamble zeros
        if (two_zero_modes) pos = pos + 1;
        if (cmd.mode == DL_DIBIT) pos = pos + 1;
        if (cmd.rst_cmd) begin
            pos = pos + 2;
        end else begin
            f = put_bits(f, {30'd0, ~cmd.test, cmd.test | cmd.page}, pos, 2);
            pos = pos + 2;
            if (cmd.use_pwd) begin
                if (two_zero_modes) pos = pos + 2;
                f = put_bits(f, cmd.pwd, pos, 32);
                pos = pos + 32;
            end
            if (!cmd.regrd) pos = pos + 1;
            if (!cmd.rd) begin
                f = put_bits(f, cmd.data, pos, 32);
                pos = pos + 32;
            end
            if (!cmd.regrd) begin
                f = put_bits(f, {29'd0, cmd.addr}, pos, 3);
                pos = pos + 3;
            end
        end
        frame = f;
        nbits = LEN_W'(pos);
    end
endmodule

// File: rtl/lfd_tick_timer.sv
module lfd_tick_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] target,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    assign expire = run && tick && (cnt == target - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run || expire) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/lf_downlink_tx.sv
module lf_downlink_tx
    import lfd_pkg::*;
#(
    parameter int START_TICKS  = 31,
    parameter int GAP_TICKS    = 20,
    parameter int ZERO_TICKS   = 18,
    parameter int ONE_TICKS    = 50,
    parameter int LZ_ONE_TICKS = 40,
    parameter int D01_TICKS    = 34,
    parameter int D10_TICKS    = 50,
    parameter int D11_TICKS    = 66,
    parameter int REF_EXTRA    = 136,
    parameter int CNT_W        = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        req_valid,
    input  logic [31:0] pwd,
    input  logic [31:0] data,
    input  logic [2:0]  addr,
    input  logic        page,
    input  logic        use_pwd,
    input  logic        test_mode,
    input  logic        reset_cmd,
    input  logic        read_cmd,
    input  logic        reg_read,
    input  logic [1:0]  dl_mode,
    output logic        field_on,
    output logic        busy,
    output logic        done
);
    localparam logic [CNT_W-1:0] T_START = CNT_W'(START_TICKS);
    localparam logic [CNT_W-1:0] T_GAP   = CNT_W'(GAP_TICKS);
    localparam logic [CNT_W-1:0] T_ZERO  = CNT_W'(ZERO_TICKS);
    localparam logic [CNT_W-1:0] T_ONE   = CNT_W'(ONE_TICKS);
    localparam logic [CNT_W-1:0] T_LZONE = CNT_W'(LZ_ONE_TICKS);
    localparam logic [CNT_W-1:0] T_D01   = CNT_W'(D01_TICKS);
    localparam logic [CNT_W-1:0] T_D10   = CNT_W'(D10_TICKS);
    localparam logic [CNT_W-1:0] T_D11   = CNT_W'(D11_TICKS);
    localparam logic [CNT_W-1:0] T_REF   = CNT_W'(ZERO_TICKS + REF_EXTRA);

    cmd_t               cmd;
    logic [FRAME_W-1:0] frame_new;
    logic [LEN_W-1:0]   nbits_new;

    tx_state_e          state;
    logic [FRAME_W-1:0] shreg;
    logic [LEN_W-1:0]   left;
    dl_mode_e           mode;
    logic [LEN_W-1:0]   step;
    logic [CNT_W-1:0]   sym_on;
    logic [CNT_W-1:0]   target;
    logic               expire;

    assign cmd = '{pwd: pwd, data: data, addr: addr, page: page, use_pwd: use_pwd,
                   test: test_mode, rst_cmd: reset_cmd, rd: read_cmd, regrd: reg_read,
                   mode: dl_mode_e'(dl_mode)};

    lfd_frame_build u_build (
        .cmd   (cmd),
        .frame (frame_new),
        .nbits (nbits_new)
    );

    assign step = (mode == DL_DIBIT) ? LEN_W'(2) : LEN_W'(1);

    // On-time of the symbol at the head of the shift register
    always_comb begin
        unique case (mode)
            DL_DIBIT: begin
                unique case (shreg[FRAME_W-1 -: 2])
                    2'b00:   sym_on = T_ZERO;
                    2'b01:   sym_on = T_D01;
                    2'b10:   sym_on = T_D10;
                    default: sym_on = T_D11;
                endcase
            end
            DL_LEADZERO: sym_on = shreg[FRAME_W-1] ? T_LZONE : T_ZERO;
            default:     sym_on = shreg[FRAME_W-1] ? T_ONE : T_ZERO;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_START: target = T_START;
            ST_REF:   target = T_REF;
            ST_ON:    target = sym_on;
            default:  target = T_GAP;
        endcase
    end

    lfd_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (state != ST_IDLE),
        .tick   (tick),
        .target (target),
        .expire (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            shreg <= '0;
            left  <= '0;
            mode  <= DL_FIXED;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    shreg <= frame_new;
                    left  <= nbits_new;
                    mode  <= cmd.mode;
                    state <= ST_START;
                end
                ST_START: if (expire) state <= (mode == DL_LONGREF) ? ST_REF : ST_ON;
                ST_REF:   if (expire) state <= ST_GAP;
                ST_ON: if (expire) begin
                    shreg <= shreg << step;
                    left  <= left - step;
                    state <= ST_GAP;
                end
                default: if (expire) begin
                    if (left >= step) begin
                        state <= ST_ON;
                    end else begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign field_on = (state == ST_IDLE) || (state == ST_ON) || (state == ST_REF);
    assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/lfd_tx_checker.sv
module lfd_tx_checker (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic req_valid,
    input logic field_on,
    input logic busy,
    input logic done
);
    logic seen;
    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> field_on);

    p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
        (seen && $rose(busy)) |-> !field_on);

    p_done_state_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (field_on && !busy));

    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_end_with_done_r10: assert property (@(posedge clk) disable iff (rst)
        (seen && $fell(busy)) |-> done);

    p_accept_when_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (seen && !busy && req_valid) |=> busy);

    p_change_on_tick_r12: assert property (@(posedge clk) disable iff (rst)
        (seen && $past(busy) && (field_on != $past(field_on))) |-> $past(tick));
endmodule

bind lf_downlink_tx lfd_tx_checker u_chk (.*);

// File: tb/lf_downlink_tx_test.sv
module lf_downlink_tx_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] pwd = '0;
    logic [31:0] data = '0;
    logic [2:0]  addr = '0;
    logic        page = 1'b0;
    logic        use_pwd = 1'b0;
    logic        test_mode = 1'b0;
    logic        reset_cmd = 1'b0;
    logic        read_cmd = 1'b0;
    logic        reg_read = 1'b0;
    logic [1:0]  dl_mode = '0;
    logic        field_on;
    logic        busy;
    logic        done;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int tick_div = 1;
    string tag = "R1";

    lf_downlink_tx uut (.*);

    always #10 clk = ~clk;

    initial begin
        int div_cnt = 0;
        forever begin
            @(negedge clk);
            if (div_cnt >= tick_div - 1) begin
                tick = 1'b1;
                div_cnt = 0;
            end else begin
                tick = 1'b0;
                div_cnt++;
            end
        end
    end

    // ---------------- behavioural reference model ----------------
    bit m_field = 1'b1;
    bit m_busy = 1'b0;
    bit m_done = 1'b0;
    int tcount = 0;
    bit seg_lvl[$];
    int seg_len[$];

    task automatic load_segments();
        bit b[$];
        int m = int'(dl_mode);
        seg_lvl.delete();
        seg_len.delete();
        if (m >= 2) b.push_back(1'b0);
        if (m == 3) b.push_back(1'b0);
        if (reset_cmd) begin
            b.push_back(1'b0); b.push_back(1'b0);
        end else begin
            b.push_back(test_mode ? 1'b0 : 1'b1);
            b.push_back(test_mode ? 1'b1 : page);
            if (use_pwd) begin
                if (m >= 2) begin b.push_back(1'b0); b.push_back(1'b0); end
                for (int i = 31; i >= 0; i--) b.push_back(pwd[i]);
            end
            if (!reg_read) b.push_back(1'b0);
            if (!read_cmd) for (int i = 31; i >= 0; i--) b.push_back(data[i]);
            if (!reg_read) for (int i = 2; i >= 0; i--) b.push_back(addr[i]);
        end
        seg_lvl.push_back(1'b0); seg_len.push_back(31);
        if (m == 1) begin
            seg_lvl.push_back(1'b1); seg_len.push_back(154);
            seg_lvl.push_back(1'b0); seg_len.push_back(20);
        end
        if (m == 3) begin
            for (int i = 0; i + 1 < b.size(); i += 2) begin
                int v = 2 * int'(b[i]) + int'(b[i+1]);
                seg_lvl.push_back(1'b1); seg_len.push_back(18 + 16 * v);
                seg_lvl.push_back(1'b0); seg_len.push_back(20);
            end
        end else begin
            foreach (b[i]) begin
                seg_lvl.push_back(1'b1);
                seg_len.push_back(b[i] ? ((m == 2) ? 40 : 50) : 18);
                seg_lvl.push_back(1'b0); seg_len.push_back(20);
            end
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_field = 1'b1; m_busy = 1'b0; m_done = 1'b0; tcount = 0;
        end else if (!m_busy) begin
            m_done = 1'b0;
            if (req_valid) begin
                load_segments();
                m_busy = 1'b1;
                m_field = seg_lvl[0];
                tcount = 0;
            end
        end else begin
            m_done = 1'b0;
            if (tick) tcount++;
            if (tcount == seg_len[0]) begin
                void'(seg_lvl.pop_front());
                void'(seg_len.pop_front());
                tcount = 0;
                if (seg_lvl.size() == 0) begin
                    m_busy = 1'b0; m_field = 1'b1; m_done = 1'b1;
                end else begin
                    m_field = seg_lvl[0];
                end
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            total++;
            if (field_on !== m_field || busy !== m_busy || done !== m_done) begin
                bad++;
                $display("FAIL %s cycle %0d: field/busy/done actual=%b%b%b expected=%b%b%b",
                         tag, cycles, field_on, busy, done, m_field, m_busy, m_done);
            end
        end
        if (cycles > 190000) begin
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic run_cmd(input string t, input logic [1:0] mode, input logic [31:0] p,
                           input logic [31:0] d, input logic [2:0] a, input logic pg,
                           input logic up, input logic tm, input logic rc,
                           input logic rd, input logic rr, input int inject);
        int n = 0;
        tag = t;
        @(negedge clk);
        dl_mode = mode; pwd = p; data = d; addr = a; page = pg; use_pwd = up;
        test_mode = tm; reset_cmd = rc; read_cmd = rd; reg_read = rr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!m_done) begin
            @(negedge clk);
            n++;
            if (n == inject) begin
                // R11: a different request while busy must change nothing
                dl_mode = ~mode; data = ~d; reset_cmd = 1'b1; req_valid = 1'b1;
            end else begin
                req_valid = 1'b0;
            end
        end
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        total++;
        if (field_on !== 1'b1 || busy !== 1'b0 || done !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset: field/busy/done actual=%b%b%b expected=100",
                     field_on, busy, done);
        end
        // R2 R3 R7 R9: fixed-bit write, page 0
        run_cmd("R3", 2'd0, 32'h0, 32'hA5C3_0F81, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        // R8: fixed-bit with password, page 1
        run_cmd("R8", 2'd0, 32'hDEAD_BEEF, 32'h1234_5678, 3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        // R6: long reference write
        run_cmd("R6", 2'd1, 32'h0, 32'hF00F_0FF0, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        // R4: leading zero with password
        run_cmd("R4", 2'd2, 32'h8000_0001, 32'hCAFE_F00D, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        // R5: dibit write with password, all four pair values present
        run_cmd("R5", 2'd3, 32'h1B1B_E4E4, 32'h9C63_36C9, 3'd6, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        // R9: dibit read, no data field
        run_cmd("R9", 2'd3, 32'h0, 32'hFFFF_FFFF, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 0);
        // R9: register read with password (no lock, data or address)
        run_cmd("R9", 2'd0, 32'h5555_AAAA, 32'hFFFF_FFFF, 3'd7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 0);
        // R7: reset command in fixed and dibit modes
        run_cmd("R7", 2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd7, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 0);
        run_cmd("R7", 2'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd7, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 0);
        // R7: test opcode in leading-zero mode
        run_cmd("R7", 2'd2, 32'h0, 32'h0000_0003, 3'd4, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0);
        // R11: request while busy ignored
        run_cmd("R11", 2'd0, 32'h0, 32'h0F0F_0F0F, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 400);
        // R12: sparse ticks
        tick_div = 3;
        run_cmd("R12", 2'd1, 32'h0, 32'h0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 0);
        tick_div = 4;
        run_cmd("R12", 2'd3, 32'h0, 32'h0, 3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 0);
        // R10: back-to-back requests with done checked each cycle
        tick_div = 1;
        run_cmd("R10", 2'd2, 32'h0, 32'h0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule